// File: doc/BRIEF.md
# Timer Clock Select and Prescaler

This block decides when a timer may advance. It produces a single-cycle count-enable strobe in the system clock domain. The timer counter consumes that strobe and is not part of this block. A 3-bit source field picks the strobe's origin. The options are: no source (counting halted), every system clock, one of four fixed divide ratios (8, 64, 256, 1024), or an edge of an external timer pin with the edge direction chosen by the field.

A free-running 10-bit prescaler counter supplies the divided rates. A ratio of 2^k fires when the k lowest counter bits are all ones. The external pin passes through a two-flop synchronizer and an edge detector before it reaches the source multiplexer. Only the pin level is used, so the pin also counts when the chip's own port logic drives it. Firmware can therefore step the timer by toggling the pin.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_i` is high, `count_en_o` is 0.
- R2: The prescaler restarts at reset. With a divided source of ratio D held through reset, the first strobe is high right after the D-th rising clock edge following reset release.
- R3: Source code 3'b000 never produces a strobe, whatever the external pin does.
- R4: Source code 3'b001 holds `count_en_o` high on every clock cycle.
- R5: Source codes 3'b010, 3'b011, 3'b100 and 3'b101 give exactly one strobe every 8, 64, 256 and 1024 clocks respectively, with a constant spacing.
- R6: Source code 3'b110 gives exactly one strobe per falling edge of `ext_pin_i`, and rising edges give none.
- R7: Source code 3'b111 gives exactly one strobe per rising edge of `ext_pin_i`, and falling edges give none.
- R8: A pin transition set up before rising clock edge E0 produces its strobe in the cycle that follows edge E0+2. The latency comes from two synchronizer flops plus the output register.
- R9: For the divided and external sources, every strobe lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| src_sel_i | input | 3 | Count source code |
| ext_pin_i | input | 1 | External timer pin level, asynchronous |
| count_en_o | output | 1 | One-cycle count-enable strobe |

## Verification
Each divided rate runs for a window that holds several periods. The pulse count and the minimum and maximum spacing are compared against the ratio, so a wrong tap width or a strobe stretched over two cycles shows up as a bad count or spacing.

The external modes get toggle trains at two different spacings. The expected totals count only the selected edge direction, which separates rising from falling detection. The spacing between strobes must equal the toggle period.

Three further checks complete the set:
- A toggle train with the source off confirms that the pin is ignored.
- A single pin step pins down the exact three-cycle latency.
- Releasing reset with the 8 and 64 ratios held confirms that the prescaler phase restarts.

// File: rtl/tmr_cs_pkg.sv
package tmr_cs_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  localparam int unsigned N_TAPS = 4;

  // True for the codes that draw on a prescaler tap
  function automatic logic is_divided(src_sel_e s);
    return (s >= SRC_DIV8) && (s <= SRC_DIV1024);
  endfunction

  // Map a divided code onto its tap index (0 = smallest ratio)
  function automatic int unsigned tap_slot(src_sel_e s);
    return int'(s) - int'(SRC_DIV8);
  endfunction

  // Next value of the strobe from the selected source
  function automatic logic pick_pulse(src_sel_e s, logic [N_TAPS-1:0] taps,
                                      logic rise, logic fall);
    logic p;
    p = 1'b0;
    case (s)
      SRC_OFF:      p = 1'b0;
      SRC_DIV1:     p = 1'b1;
      SRC_EXT_FALL: p = fall;
      SRC_EXT_RISE: p = rise;
      default:      p = is_divided(s) ? taps[tap_slot(s)] : 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tmr_cs_prescaler.sv
module tmr_cs_prescaler #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned N_TAPS = 4,
  parameter int unsigned TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10}
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic [N_TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  // Each tap fires when its low counter bits are all ones
  generate
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
      localparam int unsigned LOW = TAP_LOG2[t];
      assign tap_o[t] = &cnt_q[LOW-1:0];
    end
  endgenerate

endmodule

// File: rtl/tmr_cs_pin_edge.sv
module tmr_cs_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lvl;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl    = sync_q[STAGES-1];
  assign rise_o = lvl & ~last_q;
  assign fall_o = ~lvl & last_q;

endmodule

// File: rtl/tmr_cs_src_mux.sv
module tmr_cs_src_mux
  import tmr_cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  src_sel_e          sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              en_o
);

  logic pick;

  always_comb pick = pick_pulse(sel_i, tap_i, rise_i, fall_i);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) en_o <= 1'b0;
    else       en_o <= pick;
  end

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_cs_pkg::*;
#(
  parameter int unsigned PRE_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10}
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] src_sel_i,
  input  logic       ext_pin_i,
  output logic       count_en_o
);

  logic [N_TAPS-1:0] tap_hit;
  logic              rise_evt;
  logic              fall_evt;
  src_sel_e          sel;

  assign sel = src_sel_e'(src_sel_i);

  tmr_cs_prescaler #(
    .CNT_W   (PRE_W),
    .N_TAPS  (N_TAPS),
    .TAP_LOG2(TAP_LOG2)
  ) u_pre (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tap_o (tap_hit)
  );

  tmr_cs_pin_edge #(
    .STAGES(SYNC_STAGES)
  ) u_pin (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_i  (ext_pin_i),
    .rise_o (rise_evt),
    .fall_o (fall_evt)
  );

  tmr_cs_src_mux u_mux (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sel_i  (sel),
    .tap_i  (tap_hit),
    .rise_i (rise_evt),
    .fall_i (fall_evt),
    .en_o   (count_en_o)
  );

endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic [2:0] src_sel_i,
  input logic       count_en_o,
  input logic       rise_evt,
  input logic       fall_evt
);

  AST_RST_QUIET: assert property (@(posedge clk_i) rst_i |-> !count_en_o); // R1

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(src_sel_i) == 3'd0) |-> !count_en_o); // R3

  AST_DIV1_ALWAYS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(src_sel_i) == 3'd1) |-> count_en_o); // R4

  AST_DIV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_en_o && !$past(rst_i) && $past(src_sel_i) inside {[3'd2:3'd5]}
     && src_sel_i inside {[3'd2:3'd5]}) |=> !count_en_o); // R9

  AST_FALL_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    (fall_evt && src_sel_i == 3'd6) |=> count_en_o); // R6

  AST_RISE_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_evt && src_sel_i == 3'd7) |=> count_en_o); // R7

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_evt || fall_evt) |=> !(rise_evt || fall_evt)); // R8

endmodule

bind tmr_clk_sel tmr_clk_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .src_sel_i  (src_sel_i),
  .count_en_o (count_en_o),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt)
);

// File: tb/tmr_clk_sel_tb.sv
module tmr_clk_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       pin = 1'b0;
  logic       en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  tmr_clk_sel dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .src_sel_i  (sel),
    .ext_pin_i  (pin),
    .count_en_o (en)
  );

  typedef struct {
    string req;
    int    exp_cnt;
    int    exp_gap;
  } item_t;

  item_t exp_q[$];

  bit win_open  = 1'b0;
  bit win_close = 1'b0;
  int m_cnt = 0, m_idx = 0, m_last = 0, m_gmin = 0, m_gmax = 0;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: counts strobes and their spacing inside a window
  always @(negedge clk) begin
    if (win_open) begin
      m_idx++;
      if (en) begin
        if (m_cnt > 0) begin
          if (m_gmin == 0 || m_idx - m_last < m_gmin) m_gmin = m_idx - m_last;
          if (m_idx - m_last > m_gmax) m_gmax = m_idx - m_last;
        end
        m_last = m_idx;
        m_cnt++;
      end
    end else if (win_close && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check({it.req, " count"}, m_cnt, it.exp_cnt);
      if (it.exp_gap > 0 && it.exp_cnt >= 2) begin
        check({it.req, " min gap"}, m_gmin, it.exp_gap);
        check({it.req, " max gap"}, m_gmax, it.exp_gap);
      end
      m_cnt = 0; m_idx = 0; m_last = 0; m_gmin = 0; m_gmax = 0;
    end
  end

  task automatic open_win();
    @(negedge clk); #1 win_open = 1'b1;
  endtask

  task automatic close_win(string req, int exp_cnt, int exp_gap);
    item_t it;
    @(negedge clk); #1 win_open = 1'b0;
    it.req = req; it.exp_cnt = exp_cnt; it.exp_gap = exp_gap;
    exp_q.push_back(it);
    win_close = 1'b1;
    @(negedge clk); #1 win_close = 1'b0;
  endtask

  // Divided or constant source: window of ncyc clocks
  task automatic rate_window(string req, logic [2:0] code, int div, int ncyc);
    @(negedge clk); #1 sel = code;
    repeat (4) @(negedge clk);
    open_win();
    repeat (ncyc - 1) @(negedge clk);
    close_win(req, ncyc / div, div);
  endtask

  // Pin toggle train: ntog toggles every spc clocks
  task automatic pin_window(string req, logic [2:0] code, int ntog, int spc);
    int exp_n;
    exp_n = 0;
    @(negedge clk); #1 sel = code;
    repeat (6) @(negedge clk);
    open_win();
    for (int k = 0; k < ntog; k++) begin
      repeat (spc - 1) @(negedge clk);
      #1 pin = ~pin;
      if (code == 3'd7 && pin == 1'b1) exp_n++;
      if (code == 3'd6 && pin == 1'b0) exp_n++;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    close_win(req, exp_n, (code == 3'd0) ? 0 : 2 * spc);
  endtask

  // First strobe index after reset release for ratio div
  task automatic reset_phase(string req, logic [2:0] code, int div);
    int first;
    first = 0;
    @(negedge clk); #1 rst = 1'b1; sel = code; pin = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    for (int k = 1; k <= div + 4; k++) begin
      @(negedge clk);
      if (en && first == 0) first = k;
    end
    check(req, first, div);
  endtask

  initial begin
    // R1: quiet in reset even with a constant source selected
    repeat (2) @(negedge clk);
    #1 sel = 3'd1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 reset quiet", int'(en), 0);
    end
    #1 sel = 3'd0; rst = 1'b0;

    rate_window("R4 every clock", 3'd1, 1, 40);
    rate_window("R5 div8",    3'd2, 8,    128);
    rate_window("R5 div64",   3'd3, 64,   256);
    rate_window("R5 div256",  3'd4, 256,  1024);
    rate_window("R5 div1024", 3'd5, 1024, 3072);
    rate_window("R9 div8 width", 3'd2, 8, 64);

    pin_window("R3 off ignores pin", 3'd0, 10, 4);
    pin_window("R7 rising only", 3'd7, 10, 4);
    pin_window("R6 falling only", 3'd6, 10, 4);
    pin_window("R7 rising fast", 3'd7, 12, 2);
    pin_window("R6 falling slow", 3'd6, 6, 9);

    // R8: exact latency of a single rising step
    @(negedge clk); #1 sel = 3'd7; pin = 1'b0;
    repeat (6) @(negedge clk);
    #1 pin = 1'b1;
    @(negedge clk); check("R8 latency n1", int'(en), 0);
    @(negedge clk); check("R8 latency n2", int'(en), 0);
    @(negedge clk); check("R8 latency n3", int'(en), 1);
    @(negedge clk); check("R8 latency n4 (R9 width)", int'(en), 0);

    reset_phase("R2 phase div8", 3'd2, 8);
    reset_phase("R2 phase div64", 3'd3, 64);

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule